// File: doc/BRIEF.md
# Multi-Device Tuning Serial Bus Master

This block drives a set of three-wire tuning slaves from a single host request. Each slave takes an 8-bit word on a serial clock and data line. It acts on that word when its enable line falls. The host presents the following in one cycle:

- a device mask,
- a 5-bit tuning state and a standby bit for every device,
- a mode select,
- a divider setting.

The block latches all of them on acceptance. It then produces the serial clock, the data lanes and the enable lanes with no further host involvement.

The block has two update modes. In sequential mode, one shared data bit is driven onto every data lane. Only the enable of the device being served is pulsed, so the selected devices change state one after another in ascending index order. In simultaneous mode, all enables move together as one common enable, and each lane carries its own device's word. Every device is sent a word whatever the mask holds, and all devices take their new state on the same falling enable edge.

The divider sets, in system clocks, the following:

- the length of each clock half period,
- the enable setup and hold margins,
- half the minimum enable low time.

Software picks the setting so that the slave timing limits are met at the system clock rate.

Top module: `tune_bus_master`

## Requirements
- R1: Each word is 8 bits, sent most significant bit first. Word bits 7 and 6 are zero, bit 5 is the device's `req_stby` bit, and bits 4..0 are `req_state[5*d +: 5]` for device d.
- R2: A data lane changes only while `sclk` is low, and holds steady for the whole time `sclk` is high.
- R3: `sclk` idles low. Within a word, each high phase and each low phase between rising edges lasts exactly D system clocks, where D is the latched `cfg_div`, and a value of 0 is taken as 1.
- R4: `sclk` rises only while an enable is high. An enable is high for at least D clocks before the first rising edge of its word. After the last falling edge of `sclk`, the enable stays high for at least D clocks before it falls.
- R5: Between any two words, including words from back-to-back requests, all enables stay low for at least 2*D clocks.
- R6: In sequential mode (`req_sim`=0), only devices whose mask bit is 1 receive a word, in ascending index order. At most one enable is high at a time, and every data lane carries the same bit.
- R7: In simultaneous mode (`req_sim`=1), all enable bits are equal at every cycle. Every device receives exactly one word on its own lane, whatever the mask holds.
- R8: `busy` rises in the cycle after a request is accepted. It falls in the same cycle as the last enable falls. A request presented while `busy` is high is ignored.
- R9: A sequential-mode request with an all-zero mask is not accepted: `busy` stays low and no enable rises.
- R10: Each word contains exactly 8 rising edges of `sclk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_sim | input | 1 | 1 selects simultaneous mode, 0 selects sequential mode |
| req_mask | input | N_DEV | Devices to update in sequential mode |
| req_state | input | N_DEV*STATE_W | Tuning state per device, device d in bits [5d+4:5d] |
| req_stby | input | N_DEV | Standby bit per device |
| cfg_div | input | DIV_W | Half period and margin length in system clocks (0 acts as 1) |
| busy | output | 1 | High while a request is in progress |
| sclk | output | 1 | Serial clock, idles low |
| sda | output | N_DEV | Data lanes, identical in sequential mode |
| sen | output | N_DEV | Enable lanes, all equal in simultaneous mode |

## Verification
The in-design assertions assume two things about the inputs. First, the request fields and `cfg_div` are only meaningful in the cycle a request is accepted, because the block latches them then. Second, reset is held for at least one clock before traffic starts.

The stimulus changes `cfg_div` and the request fields only while `busy` is low. It presents each request for exactly one cycle. It deliberately pulses `req_valid` with different contents while a transfer is running, to show that such requests are dropped. Random requests cover both modes, arbitrary masks and divider values 0 through 4. Directed cases cover an empty mask, a full mask and a fixed known word.

// File: rtl/tbm_pkg.sv
// Shared types for the tuning bus master.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package tbm_pkg;

    // Phases of one serial word plus idle.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_GAP   = 3'd1,
        PH_SETUP = 3'd2,
        PH_HIGH  = 3'd3,
        PH_LOW   = 3'd4,
        PH_HOLD  = 3'd5
    } phase_t;

endpackage

// File: rtl/tbm_pick.sv
// Lowest-index selector: returns the index of the lowest set bit of a
// pending mask. Assumes callers only use idx when any is high.
module tbm_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  pend,
    output logic [IW-1:0] idx,
    output logic          any
);

    // Scan from the top down so the lowest set bit wins.
    always_comb begin
        idx = '0;
        any = |pend;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/tbm_lanes.sv
// Per-device word store and data lane driver. Latches every device's word on
// load. It presents the bit chosen by bit_idx, either per lane
// (simultaneous) or from the selected device on all lanes (sequential).
// Assumes bit_idx only changes while the serial clock is low.
module tbm_lanes #(
    parameter int N_DEV   = 4,
    parameter int STATE_W = 5,
    parameter int IW      = 2,
    parameter int FW      = STATE_W + 3,
    parameter int BW      = $clog2(FW)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [N_DEV*STATE_W-1:0]   state_in,
    input  logic [N_DEV-1:0]           stby_in,
    input  logic                       sim,
    input  logic                       active,
    input  logic [IW-1:0]              cur_dev,
    input  logic [BW-1:0]              bit_idx,
    output logic [N_DEV-1:0]           sda
);

    logic [FW-1:0]    word_q [N_DEV];
    logic [N_DEV-1:0] lane_bit;

    for (genvar g = 0; g < N_DEV; g++) begin : g_lane
        // Capture this device's word at request acceptance.
        always_ff @(posedge clk) begin
            if (!rst_n) word_q[g] <= '0;
            else if (load) word_q[g] <= {2'b00, stby_in[g], state_in[g*STATE_W +: STATE_W]};
        end
        // Current bit of this device's word.
        assign lane_bit[g] = word_q[g][bit_idx];
    end

    // Route own bits or the shared bit onto the lanes; quiet when idle.
    always_comb begin
        for (int i = 0; i < N_DEV; i++) begin
            if (!active)  sda[i] = 1'b0;
            else if (sim) sda[i] = lane_bit[i];
            else          sda[i] = lane_bit[cur_dev];
        end
    end

endmodule

// File: rtl/tbm_seq.sv
// Word sequencer: walks gap, setup, eight clock periods and hold for each
// device to be served, and drives the serial clock, enables and busy.
// Assumes request fields and cfg_div are valid in the accept cycle only.
module tbm_seq
    import tbm_pkg::*;
#(
    parameter int N_DEV = 4,
    parameter int DIV_W = 4,
    parameter int IW    = 2,
    parameter int FW    = 8,
    parameter int BW    = $clog2(FW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_sim,
    input  logic [N_DEV-1:0] req_mask,
    input  logic [DIV_W-1:0] cfg_div,
    output logic             accept,
    output logic             sim_q,
    output logic             framing,
    output logic [IW-1:0]    cur_dev,
    output logic [BW-1:0]    bit_idx,
    output logic             sclk,
    output logic [N_DEV-1:0] sen,
    output logic             busy
);

    localparam int CW = DIV_W + 1;

    phase_t           phase;
    logic [CW-1:0]    cnt;
    logic [DIV_W-1:0] div_q;
    logic [N_DEV-1:0] pend_q;
    logic [N_DEV-1:0] sel_hot;
    logic [N_DEV-1:0] pend_left;
    logic [DIV_W-1:0] div_in;
    logic [CW-1:0]    half_len;
    logic [CW-1:0]    gap_len;
    logic [CW-1:0]    gap_len_in;
    logic             pend_any;

    tbm_pick #(.N(N_DEV), .IW(IW)) u_pick (
        .pend (pend_q),
        .idx  (cur_dev),
        .any  (pend_any)
    );

    // Derive lengths and the remaining-device mask for the current word.
    always_comb begin
        div_in     = (cfg_div == '0) ? DIV_W'(1) : cfg_div;
        half_len   = {1'b0, div_q} - CW'(1);
        gap_len    = {div_q, 1'b0} - CW'(1);
        gap_len_in = {div_in, 1'b0} - CW'(1);
        sel_hot    = N_DEV'(1) << cur_dev;
        pend_left  = sim_q ? '0 : (pend_q & ~sel_hot);
        accept     = (phase == PH_IDLE) && req_valid && (req_sim || (|req_mask));
    end

    // Phase machine and per-phase cycle counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            pend_q  <= '0;
            sim_q   <= 1'b0;
            div_q   <= DIV_W'(1);
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        phase  <= PH_GAP;
                        cnt    <= gap_len_in;
                        div_q  <= div_in;
                        sim_q  <= req_sim;
                        pend_q <= req_sim ? '1 : req_mask;
                    end
                end
                PH_GAP: begin
                    if (cnt == '0) begin
                        phase   <= PH_SETUP;
                        cnt     <= half_len;
                        bit_idx <= BW'(FW - 1);
                    end else cnt <= cnt - CW'(1);
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_HIGH;
                        cnt   <= half_len;
                    end else cnt <= cnt - CW'(1);
                end
                PH_HIGH: begin
                    if (cnt == '0) begin
                        cnt <= half_len;
                        if (bit_idx == '0) phase <= PH_HOLD;
                        else begin
                            phase   <= PH_LOW;
                            bit_idx <= bit_idx - BW'(1);
                        end
                    end else cnt <= cnt - CW'(1);
                end
                PH_LOW: begin
                    if (cnt == '0) begin
                        phase <= PH_HIGH;
                        cnt   <= half_len;
                    end else cnt <= cnt - CW'(1);
                end
                PH_HOLD: begin
                    if (cnt == '0) begin
                        pend_q <= pend_left;
                        if (|pend_left) begin
                            phase <= PH_GAP;
                            cnt   <= gap_len;
                        end else phase <= PH_IDLE;
                    end else cnt <= cnt - CW'(1);
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Decode the serial clock, enables and busy from the phase.
    always_comb begin
        framing = (phase == PH_SETUP) || (phase == PH_HIGH) ||
                  (phase == PH_LOW)   || (phase == PH_HOLD);
        sclk    = (phase == PH_HIGH);
        busy    = (phase != PH_IDLE);
        if (!framing)   sen = '0;
        else if (sim_q) sen = '1;
        else            sen = sel_hot;
    end

    // R8: nothing toggles on the bus while idle.
    p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sen == '0 && !sclk));
    // R8: a request while busy leaves the latched mode untouched.
    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(sim_q));
    // R6: sequential mode never enables two devices together.
    p_one_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sim_q |-> $onehot0(sen));
    // R7: simultaneous mode moves every enable as one.
    p_common_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sim_q && (|sen)) |-> (&sen));
    // R4: the serial clock only runs inside an enable window.
    p_clock_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> (|sen));
    // R4: enables only change while the serial clock is low.
    p_enable_edge_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(|sen) || $fell(|sen)) |-> (!sclk && !$past(sclk)));
    // R9: an empty sequential request is never accepted.
    p_empty_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && !req_sim && req_mask == '0) |=> !busy);

endmodule

// File: rtl/tune_bus_master.sv
// Top of the tuning bus master: joins the sequencer with the per-device
// lane driver. Assumes a single clock and synchronous active-low reset.
module tune_bus_master #(
    parameter int N_DEV   = 4,
    parameter int STATE_W = 5,
    parameter int DIV_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_sim,
    input  logic [N_DEV-1:0]         req_mask,
    input  logic [N_DEV*STATE_W-1:0] req_state,
    input  logic [N_DEV-1:0]         req_stby,
    input  logic [DIV_W-1:0]         cfg_div,
    output logic                     busy,
    output logic                     sclk,
    output logic [N_DEV-1:0]         sda,
    output logic [N_DEV-1:0]         sen
);

    localparam int IW = (N_DEV > 1) ? $clog2(N_DEV) : 1;
    localparam int FW = STATE_W + 3;
    localparam int BW = $clog2(FW);

    logic          accept;
    logic          sim_q;
    logic          framing;
    logic [IW-1:0] cur_dev;
    logic [BW-1:0] bit_idx;

    tbm_seq #(.N_DEV(N_DEV), .DIV_W(DIV_W), .IW(IW), .FW(FW), .BW(BW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_sim   (req_sim),
        .req_mask  (req_mask),
        .cfg_div   (cfg_div),
        .accept    (accept),
        .sim_q     (sim_q),
        .framing   (framing),
        .cur_dev   (cur_dev),
        .bit_idx   (bit_idx),
        .sclk      (sclk),
        .sen       (sen),
        .busy      (busy)
    );

    tbm_lanes #(.N_DEV(N_DEV), .STATE_W(STATE_W), .IW(IW), .FW(FW), .BW(BW)) u_lanes (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .state_in (req_state),
        .stby_in  (req_stby),
        .sim      (sim_q),
        .active   (framing),
        .cur_dev  (cur_dev),
        .bit_idx  (bit_idx),
        .sda      (sda)
    );

    // R2: data lanes hold still across a high clock phase.
    p_data_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sda));
    // R6: sequential mode puts one shared bit on every lane.
    p_shared_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sim_q && (|sen)) |-> (sda == '0 || sda == '1));

endmodule

// File: tb/tb_tune_bus_master.sv
`timescale 1ns/1ps
module tb_tune_bus_master;

    localparam int N  = 4;
    localparam int SW = 5;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_sim = 1'b0;
    logic [N-1:0]  req_mask = '0;
    logic [N*SW-1:0] req_state = '0;
    logic [N-1:0]  req_stby = '0;
    logic [DW-1:0] cfg_div = 4'd1;
    logic          busy;
    logic          sclk;
    logic [N-1:0]  sda;
    logic [N-1:0]  sen;

    tune_bus_master #(.N_DEV(N), .STATE_W(SW), .DIV_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sim(req_sim),
        .req_mask(req_mask), .req_state(req_state), .req_stby(req_stby),
        .cfg_div(cfg_div), .busy(busy), .sclk(sclk), .sda(sda), .sen(sen)
    );

    always #4 clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // bench view of the running request
    bit      cur_sim = 0;
    int      cur_div = 1;
    int      log_n = 0;
    int      log_dev [64];
    logic [7:0] log_val [64];

    // monitor state
    logic       p_sclk = 0;
    logic [N-1:0] p_sen = '0;
    logic [N-1:0] p_sda = '0;
    logic       p_busy = 0;
    int hi_run = 0, lo_run = 0, en_age = 0, gap = 1000, bits = 0;
    logic [7:0] sh [N];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_word(input logic sb, input logic [4:0] st);
        return {2'b00, sb, st};
    endfunction

    // Protocol monitor sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk && !p_sclk) begin
                check(sen != '0, "R4 clock outside enable", int'(sen), 1);
                if (bits == 0) check(en_age >= cur_div, "R4 enable setup", en_age, cur_div);
                else           check(lo_run == cur_div, "R3 low phase", lo_run, cur_div);
                for (int d = 0; d < N; d++) if (sen[d]) sh[d] = {sh[d][6:0], sda[d]};
                bits++;
            end
            if (!sclk && p_sclk) check(hi_run == cur_div, "R3 high phase", hi_run, cur_div);
            if (sclk && p_sclk && sda != p_sda) check(0, "R2 data moved while high", int'(sda), int'(p_sda));
            if (sen != '0 && p_sen == '0) begin
                check(gap >= 2*cur_div, "R5 enable low time", gap, 2*cur_div);
                bits = 0;
            end
            if (sen == '0 && p_sen != '0) begin
                check(bits == 8, "R10 edges per word", bits, 8);
                check(lo_run >= cur_div, "R4 enable hold", lo_run, cur_div);
            end
            for (int d = 0; d < N; d++) begin
                if (p_sen[d] && !sen[d] && log_n < 64) begin
                    log_dev[log_n] = d;
                    log_val[log_n] = sh[d];
                    log_n++;
                end
            end
            if (sen != '0 && !cur_sim) begin
                if ($countones(sen) > 1) check(0, "R6 two enables", int'(sen), 0);
                if (sda != '0 && sda != '1) check(0, "R6 lanes differ", int'(sda), 0);
            end
            if (sen != '0 && cur_sim && sen != '1) check(0, "R7 enables split", int'(sen), 15);
            if (!busy && p_busy) check(sen == '0 && p_sen != '0, "R8 busy falls with last enable", int'(p_sen), 1);
            if (!busy && sclk) check(0, "R3 clock not idle low", 1, 0);
            hi_run = sclk ? hi_run + 1 : 0;
            lo_run = !sclk ? lo_run + 1 : 0;
            en_age = (sen != '0) ? en_age + 1 : 0;
            gap    = (sen == '0) ? gap + 1 : 0;
            p_sclk = sclk; p_sen = sen; p_sda = sda; p_busy = busy;
        end
    end

    task automatic run_req(input bit sim, input logic [N-1:0] mask,
                           input logic [N*SW-1:0] st, input logic [N-1:0] sb,
                           input logic [DW-1:0] dv, input bit poke);
        int exp_n;
        while (busy) @(negedge clk);
        @(negedge clk);
        cur_sim = sim;
        cur_div = (dv == 0) ? 1 : int'(dv);
        log_n = 0;
        req_valid = 1; req_sim = sim; req_mask = mask; req_state = st;
        req_stby = sb; cfg_div = dv;
        @(negedge clk);
        req_valid = 0;
        check(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            req_valid = 1; req_sim = !sim; req_mask = ~mask;
            req_state = ~st; req_stby = ~sb; cfg_div = dv + 4'd1;
            @(negedge clk);
            req_valid = 0;
            cfg_div = dv;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        exp_n = 0;
        for (int d = 0; d < N; d++) begin
            if (sim || mask[d]) begin
                if (exp_n < log_n) begin
                    check(log_dev[exp_n] == d, sim ? "R7 device order" : "R6 device order", log_dev[exp_n], d);
                    check(log_val[exp_n] == exp_word(sb[d], st[d*SW +: SW]), "R1 word content",
                          int'(log_val[exp_n]), int'(exp_word(sb[d], st[d*SW +: SW])));
                end
                exp_n++;
            end
        end
        check(log_n == exp_n, sim ? "R7 word count" : "R6 word count", log_n, exp_n);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        check(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int seed;
        seed = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(sclk == 0, "R3 reset clock low", int'(sclk), 0);
        check(sen == '0, "R8 reset enables low", int'(sen), 0);
        check(busy == 0, "R8 reset not busy", int'(busy), 0);
        check(sda == '0, "R2 reset data low", int'(sda), 0);

        // R1 directed literal word: standby 1, state 10110 -> 0x36 on device 2
        run_req(0, 4'b0100, 20'b00000_10110_00000_00000, 4'b0100, 4'd2, 0);
        check(log_val[0] == 8'h36, "R1 literal word", int'(log_val[0]), 54);

        // R9 empty sequential mask is refused
        @(negedge clk);
        log_n = 0;
        req_valid = 1; req_sim = 0; req_mask = '0;
        @(negedge clk);
        req_valid = 0;
        check(busy == 0, "R9 empty mask not accepted", int'(busy), 0);
        repeat (10) @(negedge clk);
        check(log_n == 0 && sen == '0, "R9 no enable from empty mask", log_n, 0);

        // R7 simultaneous with empty mask still frames all devices, divider 0
        run_req(1, 4'b0000, 20'h5A3C7, 4'b1010, 4'd0, 0);
        // R6 full mask sequential, and R8 poke while busy
        run_req(0, 4'b1111, 20'hF0E1D, 4'b0110, 4'd3, 1);
        // R7 with poke while busy
        run_req(1, 4'b0110, 20'h12345, 4'b1001, 4'd1, 1);
        // R5 back-to-back sequential requests
        run_req(0, 4'b1001, 20'hABCDE, 4'b1111, 4'd1, 0);
        run_req(0, 4'b1000, 20'h00000, 4'b0000, 4'd4, 0);

        for (int k = 0; k < 30; k++) begin
            logic [N-1:0] m;
            m = N'($urandom);
            if (m == '0) m = 4'b0010;
            run_req(1'($urandom), m, N*SW'($urandom), N'($urandom),
                    DW'($urandom_range(0, 4)), 1'($urandom));
        end
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule